// File: doc/BRIEF.md
# Clock Configuration Register with Deferred Apply

This block is a small bank of 32-bit registers behind a simple write/read bus that controls how a system clock is produced. A configuration word selects between an oscillator path and a PLL path, picks the oscillator and the PLL input, and holds one divisor per path. The block presents the source selects and the effective divide ratio of the path in use.

PLL frequency words are first written into two shadow registers. The words driven to the PLL change only when software writes a one to the self-clearing commit bit of the configuration word. Both words then move across together and an update request is raised until the PLL acknowledges. A second self-clearing bit applies a pending memory-timing word. While that change is in flight, the bus is stalled and writes have no effect. The PLL, the oscillators and the clock switch itself are outside the block. Each is represented by a request/acknowledge pair.

Top module: `clk_cfg_reg`

## Requirements
- R1: Writing 1 to bit 31 of the configuration word raises `mem_tim_req` and `bus_stall` on the next clock, and `mem_timing` then carries the timing word that was held at address 3 at the time of the write.
- R2: Writes to address 1 or 2 update only the shadow words; `pll_freq0` and `pll_freq1` do not change until a commit.
- R3: Writing 1 to bit 30 of the configuration word, with no update outstanding, loads both shadow words into `pll_freq0`/`pll_freq1` on the next clock and raises `pll_upd_req`. The request and both words then hold until `pll_upd_ack` is seen high at a clock edge.
- R4: Bits 31 and 30 of the configuration word always read back as 0, and so does bit 29.
- R5: Bit 28 selects the path: 0 gives `sys_div_ratio` = bits 19..10 plus 1, and 1 gives `sys_div_ratio` = bits 9..0 plus 1. The divisor field of the unselected path has no effect on the output.
- R6: The oscillator code (bits 23..20) is accepted on `osc_sel` only for 2 (low-frequency internal), 3 (main) or 4 (RTC). The PLL input code (bits 27..24) is accepted on `pll_in_sel` only for 3 (main). Any other code is stored and read back as written, but the output keeps its last accepted value.
- R7: After reset every register, active word and output is 0, and `sys_div_ratio` is 1.
- R8: A commit made while an update is still awaiting acknowledge captures the shadow words at that moment. They are applied on the clock at which the outstanding acknowledge is seen, and `pll_upd_req` stays high for the new update.
- R9: `mem_tim_done` seen high at a clock edge while stalled clears `bus_stall` and `mem_tim_req` on that edge.
- R10: Every bus write made while `bus_stall` is high is ignored, at any address.
- R11: The address map is: 0 is the configuration word, 1 and 2 are the two PLL frequency shadow words, and 3 is the pending memory-timing word. Each one reads back what was last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| bus_stall | output | 1 | Access suspended during a timing change |
| pll_freq0 | output | FREQ_W | Active PLL frequency word 0 |
| pll_freq1 | output | FREQ_W | Active PLL frequency word 1 |
| pll_upd_req | output | 1 | PLL update request |
| pll_upd_ack | input | 1 | PLL update acknowledge |
| mem_timing | output | TIM_W | Applied memory-timing word |
| mem_tim_req | output | 1 | Memory-timing change request |
| mem_tim_done | input | 1 | Memory-timing change complete |
| sys_use_pll | output | 1 | System clock taken from the PLL path |
| pll_in_sel | output | 4 | Last accepted PLL input code |
| osc_sel | output | 4 | Last accepted oscillator code |
| sys_div_ratio | output | 11 | Effective divide ratio (field plus 1) |

## Verification
On every cycle, the assertions check several properties. An outstanding PLL request holds both active words, and the active words move only on a commit or an acknowledge. A timing strobe stalls the bus on the next cycle and a completion releases it. The source outputs never show a reserved code, and bus writes during a stall leave the outputs unchanged. Other behaviour can only be shown by the bench's scenarios, which compare against a reference model on every clock. These cover the queued second commit and the value it finally applies, the divisor of the unselected path having no effect, reserved codes reading back as written, the zero readback of the strobe bits, and the exact cycle in which stall rises and falls.

// File: rtl/clk_cfg_pkg.sv
// Shared field positions, source codes and register selects for the
// clock configuration block. The bit positions are fixed because
// software and the bench decode the configuration word by them.
package clk_cfg_pkg;
    localparam int ADDR_W     = 2;
    localparam int BUS_W      = 32;
    localparam int SRC_W      = 4;
    localparam int DIV_W      = 10;

    localparam int BIT_MTIM   = 31;
    localparam int BIT_COMMIT = 30;
    localparam int BIT_USEPLL = 28;
    localparam int PSRC_LSB   = 24;
    localparam int OSRC_LSB   = 20;
    localparam int ODIV_LSB   = 10;
    localparam int PDIV_LSB   = 0;

    localparam logic [SRC_W-1:0] OSC_LFI    = 4'h2;
    localparam logic [SRC_W-1:0] OSC_MAIN   = 4'h3;
    localparam logic [SRC_W-1:0] OSC_RTC    = 4'h4;
    localparam logic [SRC_W-1:0] PLLIN_MAIN = 4'h3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CFG   = 2'd0,
        SEL_FREQ0 = 2'd1,
        SEL_FREQ1 = 2'd2,
        SEL_MTIM  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             use_pll;
        logic [SRC_W-1:0] pll_src;
        logic [SRC_W-1:0] osc_src;
        logic [DIV_W-1:0] osc_div;
        logic [DIV_W-1:0] pll_div;
    } cfg_t;
endpackage

// File: rtl/clk_cfg_fields.sv
// Configuration word storage, source-code filtering and divisor selection.
// Assumes wr_en is already qualified by address and stall at the top.
// Raw fields are kept for readback; outputs only take accepted codes.
module clk_cfg_fields
    import clk_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BUS_W-1:0]  wdata,
    output cfg_t              cfg_q,
    output logic              use_pll_o,
    output logic [SRC_W-1:0]  pll_src_o,
    output logic [SRC_W-1:0]  osc_src_o,
    output logic [DIV_W:0]    div_ratio_o
);
    logic [SRC_W-1:0] osc_code;
    logic [SRC_W-1:0] pll_code;
    logic             osc_ok;
    logic             pll_ok;

    assign osc_code = wdata[OSRC_LSB +: SRC_W];
    assign pll_code = wdata[PSRC_LSB +: SRC_W];
    assign osc_ok   = (osc_code == OSC_LFI) || (osc_code == OSC_MAIN) || (osc_code == OSC_RTC);
    assign pll_ok   = (pll_code == PLLIN_MAIN);

    // Store the raw configuration fields on a qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q.use_pll <= wdata[BIT_USEPLL];
            cfg_q.pll_src <= pll_code;
            cfg_q.osc_src <= osc_code;
            cfg_q.osc_div <= wdata[ODIV_LSB +: DIV_W];
            cfg_q.pll_div <= wdata[PDIV_LSB +: DIV_W];
        end
    end

    // Keep the last accepted oscillator and PLL input codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            osc_src_o <= '0;
            pll_src_o <= '0;
        end else if (wr_en) begin
            if (osc_ok) osc_src_o <= osc_code;
            if (pll_ok) pll_src_o <= pll_code;
        end
    end

    assign use_pll_o = cfg_q.use_pll;

    // Effective ratio comes only from the divisor of the selected path.
    always_comb begin
        if (cfg_q.use_pll) div_ratio_o = {1'b0, cfg_q.pll_div} + 1'b1;
        else               div_ratio_o = {1'b0, cfg_q.osc_div} + 1'b1;
    end

    // R6
    osc_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_src_o == '0) || (osc_src_o == OSC_LFI) || (osc_src_o == OSC_MAIN) || (osc_src_o == OSC_RTC));
    // R6
    pll_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_src_o == '0) || (pll_src_o == PLLIN_MAIN));
endmodule

// File: rtl/clk_cfg_pll_commit.sv
// Shadow and active PLL frequency words with a one-deep commit queue.
// Assumes commit and the shadow writes never coincide (one bus address
// per cycle). An ack with no request outstanding is ignored.
module clk_cfg_pll_commit #(
    parameter int FREQ_W = 32,
    parameter int NWORD  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NWORD-1:0]  wr_i,
    input  logic [FREQ_W-1:0] wdata,
    input  logic              commit,
    input  logic              ack,
    output logic [FREQ_W-1:0] shadow_o [NWORD],
    output logic [FREQ_W-1:0] active_o [NWORD],
    output logic              req_o
);
    logic queued_q;
    logic ack_hit;
    logic busy_next;

    assign ack_hit   = req_o && ack;
    assign busy_next = (req_o && !ack) || (ack_hit && queued_q);

    // Track the outstanding request and the queued follow-up commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_o    <= 1'b0;
            queued_q <= 1'b0;
        end else begin
            if (ack_hit) begin
                req_o    <= queued_q;
                queued_q <= 1'b0;
            end
            if (commit) begin
                if (busy_next) queued_q <= 1'b1;
                else           req_o    <= 1'b1;
            end
        end
    end

    for (genvar i = 0; i < NWORD; i++) begin : g_word
        logic [FREQ_W-1:0] queue_q;

        // Capture software writes into the shadow word.
        always_ff @(posedge clk) begin
            if (!rst_n)       shadow_o[i] <= '0;
            else if (wr_i[i]) shadow_o[i] <= wdata;
        end

        // Hold the shadow value taken by a commit that must wait.
        always_ff @(posedge clk) begin
            if (!rst_n)                     queue_q <= '0;
            else if (commit && busy_next)   queue_q <= shadow_o[i];
        end

        // Move a committed or queued value onto the PLL-side word.
        always_ff @(posedge clk) begin
            if (!rst_n)                        active_o[i] <= '0;
            else if (commit && !busy_next)     active_o[i] <= shadow_o[i];
            else if (ack_hit && queued_q)      active_o[i] <= queue_q;
        end

        // R3
        req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req_o && !ack) |=> (req_o && $stable(active_o[i])));
        // R2
        no_early_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!commit && !ack_hit) |=> $stable(active_o[i]));
    end

    // R8
    queued_resend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_hit && queued_q) |=> req_o);
endmodule

// File: rtl/clk_cfg_mem_timing.sv
// Pending memory-timing word and the stall handshake around its change.
// Assumes the strobe is only issued while not already stalled; a
// completion pulse outside a change is ignored.
module clk_cfg_mem_timing #(
    parameter int TIM_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_shadow,
    input  logic [TIM_W-1:0] wdata,
    input  logic             strobe,
    input  logic             done,
    output logic [TIM_W-1:0] shadow_o,
    output logic [TIM_W-1:0] timing_o,
    output logic             req_o
);
    // Capture the pending timing word from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)         shadow_o <= '0;
        else if (wr_shadow) shadow_o <= wdata;
    end

    // Apply the pending word and hold the request until completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timing_o <= '0;
            req_o    <= 1'b0;
        end else if (req_o) begin
            if (done) req_o <= 1'b0;
        end else if (strobe) begin
            timing_o <= shadow_o;
            req_o    <= 1'b1;
        end
    end

    // R1
    strobe_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !req_o) |=> (req_o && (timing_o == $past(shadow_o))));
    // R9
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && done) |=> !req_o);
    // R1
    stall_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !done) |=> (req_o && $stable(timing_o)));
endmodule

// File: rtl/clk_cfg_reg.sv
// Top of the clock configuration register bank. Decodes the bus,
// blocks writes during a memory-timing change, turns the two strobe
// bits into one-cycle pulses and multiplexes readback.
// Assumes FREQ_W and TIM_W are at most the bus width.
module clk_cfg_reg
    import clk_cfg_pkg::*;
#(
    parameter int FREQ_W = 32,
    parameter int TIM_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_stall,
    output logic [FREQ_W-1:0] pll_freq0,
    output logic [FREQ_W-1:0] pll_freq1,
    output logic              pll_upd_req,
    input  logic              pll_upd_ack,
    output logic [TIM_W-1:0]  mem_timing,
    output logic              mem_tim_req,
    input  logic              mem_tim_done,
    output logic              sys_use_pll,
    output logic [3:0]        pll_in_sel,
    output logic [3:0]        osc_sel,
    output logic [10:0]       sys_div_ratio
);
    localparam int NWORD = 2;

    reg_sel_e          sel;
    logic              wr_ok;
    logic              cfg_wr;
    logic [NWORD-1:0]  freq_wr;
    cfg_t              cfg_q;
    logic [FREQ_W-1:0] shadow [NWORD];
    logic [FREQ_W-1:0] active [NWORD];
    logic [TIM_W-1:0]  tim_shadow;

    assign sel        = reg_sel_e'(bus_addr);
    assign wr_ok      = bus_wr && !bus_stall;
    assign cfg_wr     = wr_ok && (sel == SEL_CFG);
    assign freq_wr[0] = wr_ok && (sel == SEL_FREQ0);
    assign freq_wr[1] = wr_ok && (sel == SEL_FREQ1);

    clk_cfg_fields u_fields (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_wr),
        .wdata       (bus_wdata),
        .cfg_q       (cfg_q),
        .use_pll_o   (sys_use_pll),
        .pll_src_o   (pll_in_sel),
        .osc_src_o   (osc_sel),
        .div_ratio_o (sys_div_ratio)
    );

    clk_cfg_pll_commit #(.FREQ_W(FREQ_W), .NWORD(NWORD)) u_pll (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (freq_wr),
        .wdata    (bus_wdata[FREQ_W-1:0]),
        .commit   (cfg_wr && bus_wdata[BIT_COMMIT]),
        .ack      (pll_upd_ack),
        .shadow_o (shadow),
        .active_o (active),
        .req_o    (pll_upd_req)
    );

    clk_cfg_mem_timing #(.TIM_W(TIM_W)) u_mtim (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_shadow (wr_ok && (sel == SEL_MTIM)),
        .wdata     (bus_wdata[TIM_W-1:0]),
        .strobe    (cfg_wr && bus_wdata[BIT_MTIM]),
        .done      (mem_tim_done),
        .shadow_o  (tim_shadow),
        .timing_o  (mem_timing),
        .req_o     (mem_tim_req)
    );

    assign bus_stall = mem_tim_req;
    assign pll_freq0 = active[0];
    assign pll_freq1 = active[1];

    // Readback mux; strobe bits and bit 29 always read as zero.
    always_comb begin
        case (sel)
            SEL_CFG:   bus_rdata = {3'b000, cfg_q};
            SEL_FREQ0: bus_rdata = 32'(shadow[0]);
            SEL_FREQ1: bus_rdata = 32'(shadow[1]);
            default:   bus_rdata = 32'(tim_shadow);
        endcase
    end

    // R10
    stall_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stall && bus_wr) |=> ($stable(sys_div_ratio) && $stable(osc_sel)
                                   && $stable(pll_in_sel) && $stable(sys_use_pll)));
    // R4
    strobe_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_CFG) |-> (bus_rdata[31:29] == 3'b000));
endmodule

// File: tb/test_clk_cfg_reg.sv
`timescale 1ns/1ps
module test_clk_cfg_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        bus_stall;
    logic [31:0] pll_freq0, pll_freq1, mem_timing;
    logic        pll_upd_req, mem_tim_req;
    logic        pll_upd_ack = 1'b0;
    logic        mem_tim_done = 1'b0;
    logic        sys_use_pll;
    logic [3:0]  pll_in_sel, osc_sel;
    logic [10:0] sys_div_ratio;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    clk_cfg_reg i_clk_cfg_reg (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_stall(bus_stall),
        .pll_freq0(pll_freq0), .pll_freq1(pll_freq1), .pll_upd_req(pll_upd_req),
        .pll_upd_ack(pll_upd_ack), .mem_timing(mem_timing), .mem_tim_req(mem_tim_req),
        .mem_tim_done(mem_tim_done), .sys_use_pll(sys_use_pll), .pll_in_sel(pll_in_sel),
        .osc_sel(osc_sel), .sys_div_ratio(sys_div_ratio)
    );

    // Behavioural reference state.
    bit          m_use, m_preq, m_stall;
    int unsigned m_psrc, m_osrc, m_odiv, m_pdiv, m_oout, m_pout, m_mtsh, m_mt;
    int unsigned m_sh[2], m_act[2];
    int unsigned m_q[$];

    task automatic chk(string tag, longint unsigned got, longint unsigned exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h t=%0t", tag, got, exp, $time);
        end
    endtask

    function automatic int unsigned m_read(int a);
        case (a)
            0: return (int'(m_use) << 28) | (m_psrc << 24) | (m_osrc << 20) | (m_odiv << 10) | m_pdiv;
            1: return m_sh[0];
            2: return m_sh[1];
            default: return m_mtsh;
        endcase
    endfunction

    // Reference model update on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_use = 0; m_preq = 0; m_stall = 0;
            m_psrc = 0; m_osrc = 0; m_odiv = 0; m_pdiv = 0;
            m_oout = 0; m_pout = 0; m_mtsh = 0; m_mt = 0;
            m_sh[0] = 0; m_sh[1] = 0; m_act[0] = 0; m_act[1] = 0;
            m_q.delete();
        end else begin
            bit w, cw, commit, busy;
            int unsigned d;
            w  = bus_wr && !m_stall;
            cw = w && bus_addr == 0;
            d  = bus_wdata;
            commit = cw && d[30];
            if (m_preq && pll_upd_ack) begin
                if (m_q.size() != 0) begin
                    m_act[0] = m_q.pop_front();
                    m_act[1] = m_q.pop_front();
                end else m_preq = 0;
            end
            busy = m_preq && !(pll_upd_ack && m_q.size() == 0 && 0);
            if (commit) begin
                if (m_preq && !(pll_upd_ack && m_q.size() == 0 && !m_preq)) begin
                    m_q.delete();
                    m_q.push_back(m_sh[0]);
                    m_q.push_back(m_sh[1]);
                end else begin
                    m_act[0] = m_sh[0]; m_act[1] = m_sh[1]; m_preq = 1;
                end
            end
            if (m_stall && mem_tim_done) m_stall = 0;
            else if (cw && d[31]) begin m_stall = 1; m_mt = m_mtsh; end
            if (w && bus_addr == 1) m_sh[0] = d;
            if (w && bus_addr == 2) m_sh[1] = d;
            if (w && bus_addr == 3) m_mtsh = d;
            if (cw) begin
                m_use = d[28]; m_psrc = (d >> 24) & 15; m_osrc = (d >> 20) & 15;
                m_odiv = (d >> 10) & 1023; m_pdiv = d & 1023;
                if (m_osrc >= 2 && m_osrc <= 4) m_oout = m_osrc;
                if (m_psrc == 3) m_pout = m_psrc;
            end
            if (busy) ; // request state already settled above
        end
    end

    // Compare every output with the model shortly after each edge.
    always @(posedge clk) begin
        #1;
        if (rst_n && !finished) begin
            chk("R3 pll_freq0", pll_freq0, m_act[0]);
            chk("R3 pll_freq1", pll_freq1, m_act[1]);
            chk("R8 pll_upd_req", pll_upd_req, m_preq);
            chk("R1 bus_stall", bus_stall, m_stall);
            chk("R9 mem_tim_req", mem_tim_req, m_stall);
            chk("R1 mem_timing", mem_timing, m_mt);
            chk("R5 sys_use_pll", sys_use_pll, m_use);
            chk("R5 sys_div_ratio", sys_div_ratio, (m_use ? m_pdiv : m_odiv) + 1);
            chk("R6 osc_sel", osc_sel, m_oout);
            chk("R6 pll_in_sel", pll_in_sel, m_pout);
            chk("R11 bus_rdata", bus_rdata, m_read(bus_addr));
        end
    end

    task automatic wr(int a, int unsigned d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 2'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(int a, output int unsigned v);
        @(negedge clk);
        bus_addr = 2'(a);
        #1 v = bus_rdata;
    endtask

    task automatic pulse_ack();
        @(negedge clk); pll_upd_ack = 1'b1;
        @(negedge clk); pll_upd_ack = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); mem_tim_done = 1'b1;
        @(negedge clk); mem_tim_done = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic int unsigned cfgw(bit use_pll, int psrc, int osrc, int odiv, int pdiv);
        return (int'(use_pll) << 28) | (psrc << 24) | (osrc << 20) | (odiv << 10) | pdiv;
    endfunction

    initial begin
        int unsigned v, cur;
        idle(3);
        @(negedge clk) rst_n = 1'b1;
        idle(1);
        // R7 reset state
        chk("R7 freq0", pll_freq0, 0);
        chk("R7 stall", bus_stall, 0);
        chk("R7 ratio", sys_div_ratio, 1);
        chk("R7 osc_sel", osc_sel, 0);
        rd(0, v); chk("R7 cfg read", v, 0);

        // R5 oscillator path, R6 accepted codes
        cur = cfgw(0, 3, 3, 9, 4);
        wr(0, cur);
        chk("R5 osc path ratio", sys_div_ratio, 10);
        chk("R6 osc main", osc_sel, 3);
        chk("R6 pll main", pll_in_sel, 3);
        cur = cfgw(1, 3, 2, 20, 4);
        wr(0, cur);
        chk("R5 pll path ratio ignores osc div", sys_div_ratio, 5);
        chk("R6 osc lfi", osc_sel, 2);
        cur = cfgw(0, 3, 4, 0, 700);
        wr(0, cur);
        chk("R5 pll div no effect", sys_div_ratio, 1);
        chk("R6 osc rtc", osc_sel, 4);
        cur = cfgw(1, 5, 1, 0, 1023);
        wr(0, cur);
        chk("R6 reserved osc kept", osc_sel, 4);
        chk("R6 reserved pll kept", pll_in_sel, 3);
        chk("R5 max ratio", sys_div_ratio, 1024);
        rd(0, v); chk("R6 raw readback", (v >> 20) & 15, 1);
        cur = cfgw(1, 3, 3, 2, 1);
        wr(0, cur);

        // R2 shadow writes, R3 commit, R4 readback zero
        wr(1, 32'hA5A5_0001);
        wr(2, 32'h5A5A_0002);
        chk("R2 freq0 deferred", pll_freq0, 0);
        chk("R2 freq1 deferred", pll_freq1, 0);
        rd(1, v); chk("R11 shadow0 read", v, 32'hA5A5_0001);
        wr(0, cur | (1 << 30));
        chk("R3 freq0 applied", pll_freq0, 32'hA5A5_0001);
        chk("R3 freq1 applied", pll_freq1, 32'h5A5A_0002);
        chk("R3 req raised", pll_upd_req, 1);
        rd(0, v); chk("R4 commit bit reads zero", v >> 29, 0);
        idle(3);
        chk("R3 req held", pll_upd_req, 1);

        // R8 commit while pending
        wr(1, 32'h1111_2222);
        wr(0, cur | (1 << 30));
        chk("R8 queued not applied", pll_freq0, 32'hA5A5_0001);
        wr(1, 32'h3333_4444);
        pulse_ack();
        chk("R8 queued applied", pll_freq0, 32'h1111_2222);
        chk("R8 req stays", pll_upd_req, 1);
        pulse_ack();
        chk("R3 req cleared", pll_upd_req, 0);
        pulse_ack();
        chk("R3 stray ack ignored", pll_freq0, 32'h1111_2222);

        // R1 strobe, R10 writes blocked, R9 release
        wr(3, 32'hC0DE_0003);
        rd(3, v); chk("R11 timing read", v, 32'hC0DE_0003);
        wr(0, cur | (1 << 31));
        chk("R1 stall raised", bus_stall, 1);
        chk("R1 timing req", mem_tim_req, 1);
        chk("R1 timing word", mem_timing, 32'hC0DE_0003);
        rd(0, v); chk("R4 strobe bit reads zero", v >> 29, 0);
        wr(0, cfgw(0, 3, 2, 50, 1));
        chk("R10 cfg write ignored", sys_div_ratio, 2);
        wr(3, 32'hDEAD_0004);
        rd(3, v); chk("R10 timing write ignored", v, 32'hC0DE_0003);
        wr(0, cur | (1 << 30));
        chk("R10 commit ignored", pll_upd_req, 0);
        idle(2);
        chk("R1 stall held", bus_stall, 1);
        pulse_done();
        chk("R9 stall released", bus_stall, 0);
        wr(0, cfgw(0, 3, 2, 50, 1));
        chk("R10 write after release", sys_div_ratio, 51);

        // Ack and commit in the same cycle
        wr(2, 32'h7777_0005);
        wr(0, cur | (1 << 30));
        @(negedge clk);
        pll_upd_ack = 1'b1; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = cur | (1 << 30);
        @(negedge clk);
        pll_upd_ack = 1'b0; bus_wr = 1'b0;
        chk("R3 commit on ack edge", pll_upd_req, 1);
        pulse_ack();
        idle(4);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule